// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block turns an asynchronous serial line into framed words. A sample tick runs every `div_i` clocks, and each bit period is 16 ticks, or 8 ticks when the fast mode is selected. A falling edge on the synchronized line starts a frame. The start bit is confirmed half a bit later. Data bits are then sampled at mid-bit, least significant first, followed by one or two stop bits. The completed word appears on a valid/ready output stream that behaves as a one-entry receive data register. The frame settings are word length, parity, stop bits, sample rate and line inversion. They are plain inputs, so they can be wired from the same register that sets up the companion transmitter.

Several status conditions are kept next to the stream. An overrun flag marks a word that was lost because the previous one had not been taken. Once it is set, the flag blocks new words until software clears it, unless overrun detection is turned off. An idle-line flag rises once after each burst of traffic. A parity-error bit is stored alongside the word. The transmitter's buffer-empty and transfer-complete flags come in as inputs. They are merged with the receive flags into a single interrupt line and into two DMA request lines. Software clears flags through a write-one-to-clear strobe.

Back-pressure on the stream is simple. The word stays on `rx_data_o` with `rx_valid_o` high until `rx_ready_i` is seen high on a clock edge. There is no queue behind this register. A frame that completes while the word is still pending is an overrun. If overrun detection is disabled, the new frame replaces the pending word instead.

Top module: `uart_rx_top`

## Requirements
- R1: After reset, `rx_valid_o`, `ovr_o`, `idle_o`, `irq_o`, `dma_rx_req_o` and `dma_tx_req_o` are all low.
- R2: The line passes through a two-flop synchronizer, and one sample tick occurs every `div_i` clocks (a value of 0 acts as 1). A bit lasts 16 ticks, or 8 ticks when `over8_i` is 1. The word length code `wlen_i` gives 8 bits for 00, 9 bits for 01 and 7 bits for 10. The first bit received lands in `rx_data_o[0]`, and unused upper bits read 0. When parity is on, the parity bit is the last bit of the word and is included in it. `stop2_i` selects two stop bits instead of one.
- R3: A low pulse that has ended before the mid-point of the start bit produces no word.
- R4: `rx_valid_o` rises when a frame lands and falls after a cycle with `rx_valid_o` and `rx_ready_i` both high. While the word is unread and overrun detection is on, `rx_data_o` stays unchanged.
- R5: A frame that completes while a word is still pending sets `ovr_o`, is discarded, and leaves the pending word in place.
- R6: While `ovr_o` is set, completed frames are discarded and `rx_valid_o` does not rise. A cycle with `clr_we_i` high and `clr_bits_i[0]` high clears `ovr_o`.
- R7: With `ovr_dis_i` high, `ovr_o` never sets, and a new frame overwrites the pending word.
- R8: After a frame, if the line stays high for one full frame time (start bit, word and stop bits), `idle_o` sets. `clr_bits_i[1]` with `clr_we_i` clears it. The flag only sets again after a further frame.
- R9: `par_err_o` is stored with each word when `par_en_i` is high. It is 1 when the XOR of all received word bits differs from `par_odd_i`. A parity error does not stop `rx_valid_o` from rising.
- R10: With `rx_inv_i` high, the line is taken as inverted, so idle is low and the start bit is high.
- R11: `irq_o` is the OR of four terms: `ie_rx_i` with (`rx_valid_o` or `ovr_o`), `ie_txe_i` with `txe_i`, `ie_tc_i` with `tc_i`, and `ie_idle_i` with `idle_o`.
- R12: `dma_rx_req_o` is `rx_valid_o` gated by `dma_rx_en_i`. `dma_tx_req_o` is `txe_i` gated by `dma_tx_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line |
| div_i | input | DIV_W | Clocks per sample tick |
| over8_i | input | 1 | 8 ticks per bit instead of 16 |
| wlen_i | input | 2 | Word length code |
| par_en_i | input | 1 | Parity checking on |
| par_odd_i | input | 1 | Odd parity when high |
| stop2_i | input | 1 | Two stop bits |
| rx_inv_i | input | 1 | Invert line polarity |
| ovr_dis_i | input | 1 | Overrun detection off |
| rx_data_o | output | DATA_W | Received word |
| rx_valid_o | output | 1 | Word pending (data-ready) |
| rx_ready_i | input | 1 | Consumer takes the word |
| par_err_o | output | 1 | Parity error of the held word |
| ovr_o | output | 1 | Overrun flag |
| idle_o | output | 1 | Idle-line flag |
| clr_we_i | input | 1 | Clear strobe |
| clr_bits_i | input | 2 | Bit 0 clears overrun, bit 1 clears idle |
| txe_i | input | 1 | Transmit buffer empty, from transmitter |
| tc_i | input | 1 | Transmit complete, from transmitter |
| ie_rx_i | input | 1 | Interrupt enable, data-ready and overrun |
| ie_txe_i | input | 1 | Interrupt enable, transmit empty |
| ie_tc_i | input | 1 | Interrupt enable, transmit complete |
| ie_idle_i | input | 1 | Interrupt enable, idle |
| dma_rx_en_i | input | 1 | Receive DMA enable |
| dma_tx_en_i | input | 1 | Transmit DMA enable |
| irq_o | output | 1 | Interrupt |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |

## Verification
The bench sends a second frame into an unread register. A design that let the new word overwrite the old one, or skipped the overrun flag, would show the second value or a clear flag. It then sends a third frame after the read and before the clear. A receiver that did not freeze would raise data-ready again on that frame. The idle flag is checked three times: shortly after a burst, after a long quiet line, and again after it has been cleared, to catch a flag that fires too early, fires without traffic, or keeps re-firing on silence. Short start glitches, inverted polarity, 7-bit words with two stop bits at 8 ticks per bit, and 9-bit words with good and bad parity each exercise one sampling path where an off-by-one in the bit counter or a wrong parity sense would corrupt the word.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // word length code: 00 -> 8, 01 -> 9, 10 -> 7 bits
  function automatic int unsigned word_bits(input logic [1:0] code);
    case (code)
      2'b01:   return 9;
      2'b10:   return 7;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic inv_i,
  output logic rx_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], rxd_i ^ inv_i};
  end

  assign rx_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned OS_W   = 5,
  localparam int unsigned BITS_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              os8_i,
  input  logic [BITS_W-1:0] nbits_i,
  input  logic              stop2_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o
);
  rx_state_e         state_q;
  logic [OS_W-1:0]   scnt_q;
  logic [BITS_W-1:0] bcnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              extra_stop_q;
  logic [OS_W-1:0]   half_m1;
  logic [OS_W-1:0]   full_m1;
  logic [BITS_W-1:0] shamt;

  assign half_m1 = os8_i ? OS_W'(3) : OS_W'(7);
  assign full_m1 = os8_i ? OS_W'(7) : OS_W'(15);
  assign shamt   = BITS_W'(DATA_W) - nbits_i;
  assign busy_o  = (state_q != RX_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_WAIT;
      scnt_q       <= '0;
      bcnt_q       <= '0;
      sh_q         <= '0;
      extra_stop_q <= 1'b0;
      done_o       <= 1'b0;
      data_o       <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_WAIT: begin
            if (!rx_i) begin
              state_q <= RX_START;
              scnt_q  <= '0;
            end
          end
          RX_START: begin
            if (scnt_q == half_m1) begin
              scnt_q  <= '0;
              bcnt_q  <= '0;
              state_q <= rx_i ? RX_WAIT : RX_BITS;
            end else begin
              scnt_q <= scnt_q + 1'b1;
            end
          end
          RX_BITS: begin
            if (scnt_q == full_m1) begin
              scnt_q <= '0;
              sh_q   <= {rx_i, sh_q[DATA_W-1:1]};
              if (bcnt_q == nbits_i - 1'b1) begin
                state_q      <= RX_STOP;
                extra_stop_q <= stop2_i;
              end else begin
                bcnt_q <= bcnt_q + 1'b1;
              end
            end else begin
              scnt_q <= scnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (scnt_q == full_m1) begin
              scnt_q <= '0;
              if (extra_stop_q) begin
                extra_stop_q <= 1'b0;
              end else begin
                done_o  <= 1'b1;
                data_o  <= sh_q >> shamt;
                state_q <= RX_WAIT;
              end
            end else begin
              scnt_q <= scnt_q + 1'b1;
            end
          end
          default: state_q <= RX_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              ovr_dis_i,
  input  logic              rd_i,
  input  logic              clr_we_i,
  input  logic [1:0]        clr_bits_i,
  input  logic              quiet_i,
  input  logic              tick_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  output logic              rxne_o,
  output logic              ovr_o,
  output logic              idle_o,
  output logic              perr_o,
  output logic [DATA_W-1:0] rdr_o
);
  logic              load;
  logic              ovr_set;
  logic              idle_hit;
  logic              armed_q;
  logic [IDLE_W-1:0] icnt_q;

  assign load    = done_i && (ovr_dis_i || (!ovr_o && (!rxne_o || rd_i)));
  assign ovr_set = done_i && !ovr_dis_i && rxne_o && !rd_i;
  assign idle_hit = !done_i && quiet_i && tick_i && armed_q &&
                    (icnt_q == idle_lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxne_o <= 1'b0;
      rdr_o  <= '0;
      perr_o <= 1'b0;
    end else if (load) begin
      rxne_o <= 1'b1;
      rdr_o  <= data_i;
      perr_o <= par_en_i && ((^data_i) != par_odd_i);
    end else if (rd_i) begin
      rxne_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ovr_o <= 1'b0;
    else if (ovr_set)                    ovr_o <= 1'b1;
    else if (clr_we_i && clr_bits_i[0])  ovr_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      icnt_q  <= '0;
      idle_o  <= 1'b0;
    end else begin
      if (done_i) begin
        armed_q <= 1'b1;
        icnt_q  <= '0;
      end else if (!quiet_i) begin
        icnt_q <= '0;
      end else if (tick_i && armed_q) begin
        if (idle_hit) begin
          armed_q <= 1'b0;
          icnt_q  <= '0;
        end else begin
          icnt_q <= icnt_q + 1'b1;
        end
      end
      if (idle_hit)                        idle_o <= 1'b1;
      else if (clr_we_i && clr_bits_i[1])  idle_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              over8_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              rx_inv_i,
  input  logic              ovr_dis_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              par_err_o,
  output logic              ovr_o,
  output logic              idle_o,
  input  logic              clr_we_i,
  input  logic [1:0]        clr_bits_i,
  input  logic              txe_i,
  input  logic              tc_i,
  input  logic              ie_rx_i,
  input  logic              ie_txe_i,
  input  logic              ie_tc_i,
  input  logic              ie_idle_i,
  input  logic              dma_rx_en_i,
  input  logic              dma_tx_en_i,
  output logic              irq_o,
  output logic              dma_rx_req_o,
  output logic              dma_tx_req_o
);
  localparam int unsigned BITS_W = $clog2(DATA_W + 1);
  localparam int unsigned OS_W   = 5;
  localparam int unsigned IDLE_W = $clog2((DATA_W + 3) * 16 + 1);

  logic              rx_s;
  logic              tick;
  logic              done;
  logic              busy;
  logic [DATA_W-1:0] frame_data;
  logic [BITS_W-1:0] nbits;
  logic [IDLE_W-1:0] idle_lim;

  assign nbits    = BITS_W'(word_bits(wlen_i));
  assign idle_lim = IDLE_W'((32'(nbits) + (stop2_i ? 32'd3 : 32'd2)) << (over8_i ? 3 : 4));

  uart_rx_sync #(.STAGES(2)) sync_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .inv_i(rx_inv_i), .rx_o(rx_s)
  );

  uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OS_W(OS_W)) frame_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rx_i   (rx_s),
    .os8_i  (over8_i),
    .nbits_i(nbits),
    .stop2_i(stop2_i),
    .done_o (done),
    .data_o (frame_data),
    .busy_o (busy)
  );

  uart_rx_status #(.DATA_W(DATA_W), .IDLE_W(IDLE_W)) status_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .data_i    (frame_data),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .ovr_dis_i (ovr_dis_i),
    .rd_i      (rx_valid_o && rx_ready_i),
    .clr_we_i  (clr_we_i),
    .clr_bits_i(clr_bits_i),
    .quiet_i   (!busy && rx_s),
    .tick_i    (tick),
    .idle_lim_i(idle_lim),
    .rxne_o    (rx_valid_o),
    .ovr_o     (ovr_o),
    .idle_o    (idle_o),
    .perr_o    (par_err_o),
    .rdr_o     (rx_data_o)
  );

  assign irq_o = (ie_rx_i && (rx_valid_o || ovr_o)) || (ie_txe_i && txe_i) ||
                 (ie_tc_i && tc_i) || (ie_idle_i && idle_o);
  assign dma_rx_req_o = rx_valid_o && dma_rx_en_i;
  assign dma_tx_req_o = txe_i && dma_tx_en_i;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int unsigned DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              ovr_o,
  input logic              ovr_dis_i,
  input logic              idle_o,
  input logic              ie_idle_i,
  input logic              irq_o,
  input logic              dma_rx_req_o
);
  // R5
  ovr_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(rx_valid_o));

  // R7
  ovr_dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> !$past(ovr_dis_i));

  // R6
  ovr_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_dis_i) |=> !$rose(rx_valid_o));

  // R4
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i && !ovr_dis_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R12
  dma_rx_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_req_o |-> rx_valid_o);

  // R11
  idle_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && ie_idle_i) |-> irq_o);
endmodule

bind uart_rx_top uart_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_o  (rx_valid_o),
  .rx_ready_i  (rx_ready_i),
  .rx_data_o   (rx_data_o),
  .ovr_o       (ovr_o),
  .ovr_dis_i   (ovr_dis_i),
  .idle_o      (idle_o),
  .ie_idle_i   (ie_idle_i),
  .irq_o       (irq_o),
  .dma_rx_req_o(dma_rx_req_o)
);

// File: tb/uart_rx_top_tb_top.sv
module uart_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] div = 16'd2;
  logic        over8 = 1'b0;
  logic [1:0]  wlen = 2'b00;
  logic        par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, inv = 1'b0, ovr_dis = 1'b0;
  logic        rx_ready = 1'b0;
  logic        clr_we = 1'b0;
  logic [1:0]  clr_bits = 2'b00;
  logic        txe = 1'b0, tc = 1'b0;
  logic        ie_rx = 1'b0, ie_txe = 1'b0, ie_tc = 1'b0, ie_idle = 1'b0;
  logic        dma_rx_en = 1'b0, dma_tx_en = 1'b0;
  logic [8:0]  rx_data;
  logic        rx_valid, par_err, ovr, idle, irq, dma_rx_req, dma_tx_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit auto_rd = 1'b0;
  bit finished = 1'b0;
  int rd_req = 0;
  int rd_done = 0;

  typedef struct packed {
    logic [8:0] d;
    logic       pe;
  } exp_t;
  exp_t sbq[$];
  exp_t cur;

  always #5 clk = ~clk;

  uart_rx_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .div_i(div), .over8_i(over8),
    .wlen_i(wlen), .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .rx_inv_i(inv), .ovr_dis_i(ovr_dis), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .par_err_o(par_err), .ovr_o(ovr), .idle_o(idle),
    .clr_we_i(clr_we), .clr_bits_i(clr_bits), .txe_i(txe), .tc_i(tc),
    .ie_rx_i(ie_rx), .ie_txe_i(ie_txe), .ie_tc_i(ie_tc), .ie_idle_i(ie_idle),
    .dma_rx_en_i(dma_rx_en), .dma_tx_en_i(dma_tx_en), .irq_o(irq),
    .dma_rx_req_o(dma_rx_req), .dma_tx_req_o(dma_tx_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [1:0] code);
    return (code == 2'b01) ? 9 : (code == 2'b10) ? 7 : 8;
  endfunction

  task automatic level(input logic v, input int n);
    rxd = v ^ inv;
    repeat (n) @(negedge clk);
  endtask

  // driver: optionally pushes the expected word, then drives the frame
  task automatic send(input logic [8:0] w, input bit push);
    int nb = nb_of(wlen);
    int bp = int'(div) * (over8 ? 8 : 16);
    logic [8:0] m = w & 9'((1 << nb) - 1);
    exp_t e;
    e.d  = m;
    e.pe = par_en && ((^m) != par_odd);
    if (push) sbq.push_back(e);
    level(1'b0, bp);
    for (int i = 0; i < nb; i++) level(m[i], bp);
    level(1'b1, bp);
    if (stop2) level(1'b1, bp);
  endtask

  task automatic do_read();
    rd_req++;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear(input logic [1:0] b);
    clr_bits = b;
    clr_we   = 1'b1;
    @(negedge clk);
    clr_we   = 1'b0;
    clr_bits = 2'b00;
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each word, or serves manual reads
  always @(negedge clk) begin
    if (rx_ready) begin
      rx_ready = 1'b0;
    end else if (auto_rd && rx_valid) begin
      if (sbq.size() == 0) begin
        chk("R4 unexpected word", 32'd1, 32'd0);
      end else begin
        cur = sbq.pop_front();
        chk("R2 word value", 32'(rx_data), 32'(cur.d));
        chk("R9 parity flag", 32'(par_err), 32'(cur.pe));
      end
      rx_ready = 1'b1;
    end else if (rd_req != rd_done) begin
      rd_done++;
      rx_ready = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(rx_valid), 0);
    chk("R1 ovr", 32'(ovr), 0);
    chk("R1 idle", 32'(idle), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma", 32'({dma_rx_req, dma_tx_req}), 0);

    // R2 8-bit words, 16 ticks per bit, scoreboard with auto reads
    auto_rd = 1'b1;
    send(9'h055, 1'b1);
    send(9'h0A3, 1'b1);
    send(9'h000, 1'b1);
    send(9'h0FF, 1'b1);
    send(9'h03C, 1'b1);
    repeat (100) @(negedge clk);
    chk("R8 idle not yet", 32'(idle), 0);
    chk("R2 all words seen", 32'(sbq.size()), 0);
    repeat (400) @(negedge clk);
    chk("R8 idle after quiet frame", 32'(idle), 1);
    ie_idle = 1'b1;
    #1;
    chk("R11 idle irq", 32'(irq), 1);
    clear(2'b10);
    chk("R8 idle cleared", 32'(idle), 0);
    chk("R11 irq drops", 32'(irq), 0);
    repeat (800) @(negedge clk);
    chk("R8 idle fires once per burst", 32'(idle), 0);
    ie_idle = 1'b0;

    // R9 9-bit words with parity bit at top
    wlen = 2'b01; par_en = 1'b1; par_odd = 1'b0;
    send(9'h05A, 1'b1);
    send(9'h05B, 1'b1);
    par_odd = 1'b1;
    send(9'h05B, 1'b1);
    send(9'h15B, 1'b1);
    repeat (64) @(negedge clk);
    chk("R9 parity words seen", 32'(sbq.size()), 0);

    // R2 7-bit words, 8 ticks per bit, two stop bits
    par_en = 1'b0; par_odd = 1'b0; wlen = 2'b10; over8 = 1'b1; stop2 = 1'b1;
    send(9'h02D, 1'b1);
    send(9'h055, 1'b1);
    send(9'h07F, 1'b1);
    repeat (64) @(negedge clk);
    chk("R2 short words seen", 32'(sbq.size()), 0);

    // R10 inverted line
    wlen = 2'b00; over8 = 1'b0; stop2 = 1'b0;
    inv = 1'b1; rxd = 1'b0;
    repeat (64) @(negedge clk);
    send(9'h0C3, 1'b1);
    send(9'h081, 1'b1);
    repeat (64) @(negedge clk);
    chk("R10 inverted words seen", 32'(sbq.size()), 0);
    inv = 1'b0; rxd = 1'b1;
    repeat (64) @(negedge clk);

    // R5 R6 overrun and freeze, manual reads
    auto_rd = 1'b0; ie_rx = 1'b1;
    send(9'h011, 1'b0);
    repeat (4) @(negedge clk);
    chk("R4 word pending", 32'(rx_valid), 1);
    repeat (200) @(negedge clk);
    chk("R4 word held under back-pressure", 32'(rx_data), 32'h11);
    send(9'h022, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 ovr set", 32'(ovr), 1);
    chk("R5 old word kept", 32'(rx_data), 32'h11);
    do_read();
    chk("R4 read clears valid", 32'(rx_valid), 0);
    chk("R11 ovr irq", 32'(irq), 1);
    send(9'h033, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6 frozen valid", 32'(rx_valid), 0);
    clear(2'b01);
    chk("R6 ovr cleared", 32'(ovr), 0);
    send(9'h044, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6 valid after clear", 32'(rx_valid), 1);
    chk("R6 word after clear", 32'(rx_data), 32'h44);
    chk("R11 rx irq", 32'(irq), 1);
    dma_rx_en = 1'b1;
    #1;
    chk("R12 rx dma", 32'(dma_rx_req), 1);
    dma_rx_en = 1'b0;
    #1;
    chk("R12 rx dma gated", 32'(dma_rx_req), 0);
    do_read();
    ie_rx = 1'b0;

    // R7 overrun detection off
    ovr_dis = 1'b1;
    send(9'h066, 1'b0);
    send(9'h077, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 no ovr", 32'(ovr), 0);
    chk("R7 overwrite", 32'(rx_data), 32'h77);
    do_read();
    ovr_dis = 1'b0;

    // R3 short start glitch
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk("R3 glitch ignored", 32'(rx_valid), 0);

    // R11 R12 transmitter flags
    txe = 1'b1;
    #1;
    chk("R11 txe masked", 32'(irq), 0);
    chk("R12 tx dma gated", 32'(dma_tx_req), 0);
    dma_tx_en = 1'b1; ie_txe = 1'b1;
    #1;
    chk("R12 tx dma", 32'(dma_tx_req), 1);
    chk("R11 txe irq", 32'(irq), 1);
    txe = 1'b0; tc = 1'b1;
    #1;
    chk("R11 tc masked", 32'(irq), 0);
    ie_tc = 1'b1;
    #1;
    chk("R11 tc irq", 32'(irq), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule